// File: doc/BRIEF.md
# Daisy-Chained TDM Slot Transmitter

This block is the sensor end of a shared time-division audio bus. Several identical nodes hang on one serial data line and one bit clock, and none of them holds a slot address. Each node learns its slot from its place in a word-select relay. The clock master drives the word-select input of the first node. Each node drives the word-select input of the next node, with a delay of exactly one 32-clock slot. So node 0 talks in slot 0, node 1 in slot 1, and so on, for up to 16 nodes.

When a node sees a rising edge on its word-select input, it captures a 24-bit two's complement sample from its parallel input. It then sends that sample MSB first, one bit per bit-clock rising edge, and asserts a drive enable while it sends. A receiver takes each bit one rising edge after it was launched. The enable drops right after the LSB, so that the next node can use the line. The line stays released for the last 8 clocks of the slot. Outside the enable window the data output is held at 0, and an external tri-state buffer or pull-down uses the enable.

Top module: `tdm_chain_tx`

## Requirements
- R1: While rst_ni is low, and afterwards until a frame start, sd_o, sd_oe_o and ws_o are all 0.
- R2: A frame start is a bit-clock rising edge at which ws_i is sampled 1 after it was sampled 0 at the previous edge (the first edge after reset counts ws_i as previously 0). Keeping ws_i at 1 does not start another frame.
- R3: sample_i is captured at the frame-start edge (edge 0). Changes on sample_i after edge 0 have no effect on the bits sent in that slot.
- R4: After edge k of the slot, for k = 0..23, sd_o carries bit 23-k of the captured sample. Bit 23 is the sign bit and goes first.
- R5: sd_oe_o is 1 after edges 0..23 of the slot and 0 after edges 24..31, so the line is released right after the LSB for the 8 tail clocks.
- R6: ws_o is 1 only after edge 31 of the slot, for one clock. A downstream node therefore samples it at edge 32, which is its own edge 0.
- R7: sd_o is 0 whenever sd_oe_o is 0.
- R8: A frame start that comes while a slot is still running restarts the slot at once. It captures the new sample, sends its MSB, and cancels the word-select pulse still pending from the older slot.
- R9: ws_i may fall at any edge after the frame start. The fall does not change the running slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ws_i | input | 1 | Word select from the master or from the upstream node |
| sample_i | input | 24 | Parallel two's complement sample |
| sd_o | output | 1 | Serial data bit, MSB first |
| sd_oe_o | output | 1 | Drive enable for the shared data line |
| ws_o | output | 1 | Word select to the downstream node |

## Verification
Two functions can fall on the same clock edge: a fresh frame start from ws_i, and the slot timer's own progress (shifting, releasing the line, or firing the downstream word-select pulse). The bench provokes this by raising ws_i again in the middle of a slot, twelve clocks after the previous start. Every output is then judged against the new slot's timeline. The expected values are the new sample's MSB on the following cycle, and no ws_o pulse at the point where the older slot would have fired it. The vector frames also vary how long ws_i stays high, from one clock to nearly the whole frame. This shows that the falling edge has no effect on the timeline.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;
  localparam int unsigned WORD_W_DEF = 24;
  localparam int unsigned SLOT_W_DEF = 32;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SLOT = 1'b1
  } slot_state_e;
endpackage

// File: rtl/tdm_ws_edge.sv
module tdm_ws_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ws_i,
  output logic start_o
);
  logic ws_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ws_q <= 1'b0;
    else         ws_q <= ws_i;
  end

  assign start_o = ws_i & ~ws_q;

  // a held-high word select never yields two starts in a row
  p_single_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
  import tdm_chain_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned SLOT_W = SLOT_W_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic shift_o,
  output logic oe_o,
  output logic relay_o
);
  localparam int unsigned CNT_W = $clog2(SLOT_W);
  localparam logic [CNT_W-1:0] LSB_CNT   = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] RELAY_CNT = CNT_W'(SLOT_W - 2);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(SLOT_W - 1);

  slot_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             in_slot;

  assign in_slot = (state_q == ST_SLOT);
  assign load_o  = start_i;
  assign shift_o = in_slot && !start_i && (cnt_q < LSB_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_SLOT;
      cnt_q   <= '0;
    end else if (in_slot) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_CNT) state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           oe_o <= 1'b0;
    else if (start_i)                      oe_o <= 1'b1;
    else if (in_slot && cnt_q == LSB_CNT)  oe_o <= 1'b0;
  end

  // restart cancels the pending relay pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      relay_o <= 1'b0;
    else if (start_i) relay_o <= 1'b0;
    else              relay_o <= in_slot && (cnt_q == RELAY_CNT);
  end

  p_start_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (oe_o && in_slot && cnt_q == '0));
  p_release_lsb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_slot && !start_i && cnt_q == LSB_CNT) |=> !oe_o);
  p_tail_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_slot && cnt_q > LSB_CNT) |-> !oe_o);
  p_relay_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relay_o |-> (in_slot && cnt_q == LAST_CNT));
  p_relay_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relay_o |=> !relay_o);
endmodule

// File: rtl/tdm_shifter.sv
module tdm_shifter #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end

  assign bit_o = sr_q[WORD_W-1];

  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sr_q == $past(data_i)));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(sr_q));
endmodule

// File: rtl/tdm_chain_tx.sv
module tdm_chain_tx
  import tdm_chain_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned SLOT_W = SLOT_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ws_i,
  input  logic [WORD_W-1:0] sample_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic              ws_o
);
  logic start, load, shift, oe, relay, tx_bit;

  tdm_ws_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ws_i    (ws_i),
    .start_o (start)
  );

  tdm_slot_timer #(
    .WORD_W (WORD_W),
    .SLOT_W (SLOT_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .load_o  (load),
    .shift_o (shift),
    .oe_o    (oe),
    .relay_o (relay)
  );

  tdm_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .data_i  (sample_i),
    .bit_o   (tx_bit)
  );

  // released line reads as 0 for the external pull-down
  assign sd_o    = oe & tx_bit;
  assign sd_oe_o = oe;
  assign ws_o    = relay;

  p_relay_in_tail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ws_o |-> !sd_oe_o);
  p_first_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (sd_oe_o && sd_o == $past(sample_i[WORD_W-1])));
endmodule

// File: tb/tb_tdm_chain_tx.sv
module tb_tdm_chain_tx;
  localparam int FRAME = 64;
  localparam int NVEC  = 6;
  localparam logic [23:0] VS [NVEC] = '{24'h800000, 24'h7FFFFF, 24'h000001,
                                        24'hFFFFFF, 24'hA5C3F1, 24'h000000};
  localparam int VH [NVEC] = '{1, 2, 16, 32, 63, 5};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ws_i = 1'b0;
  logic [23:0] sample_i = '0;
  logic sd_o, sd_oe_o, ws_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tdm_chain_tx dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .ws_i     (ws_i),
    .sample_i (sample_i),
    .sd_o     (sd_o),
    .sd_oe_o  (sd_oe_o),
    .ws_o     (ws_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ws_i rises for edge 0, stays high for hi edges; checks after each edge k
  task automatic run_frame(input logic [23:0] s, input int hi, input int len);
    @(negedge clk);
    ws_i = 1'b1;
    sample_i = s;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k < 24) begin
        check("R4 data bit", int'(sd_o), int'(s[23-k]));
        check("R5 enable on", int'(sd_oe_o), 1);
      end else begin
        check("R5 enable off after LSB", int'(sd_oe_o), 0);
        check("R7 quiet data", int'(sd_o), 0);
      end
      check("R6 relay pulse", int'(ws_o), (k == 31) ? 1 : 0);
      ws_i = (k + 1 < hi);           // R9 fall at varying edge, R2 held level
      if (k == 0) sample_i = ~s;     // R3 late change ignored
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset sd", int'(sd_o), 0);
    check("R1 reset oe", int'(sd_oe_o), 0);
    check("R1 reset ws_o", int'(ws_o), 0);
    rst_ni = 1'b1;
    sample_i = 24'h123456;
    repeat (5) @(negedge clk);
    check("R1 idle oe", int'(sd_oe_o), 0);
    check("R1 idle ws_o", int'(ws_o), 0);

    for (int v = 0; v < NVEC; v++) run_frame(VS[v], VH[v], FRAME);

    // R2: ws_i held across a whole frame and beyond; one slot only
    run_frame(24'hC0FFEE, 70, FRAME);
    ws_i = 1'b0;

    // R8: restart twelve edges into a slot
    run_frame(24'h5A5A5A, 1, 11);
    run_frame(24'h0F0F0F, 1, FRAME);

    // R2: ws_i high coming out of reset starts a frame at the first edge
    @(negedge clk);
    rst_ni = 1'b0;
    ws_i = 1'b1;
    sample_i = 24'h400001;
    @(negedge clk);
    check("R1 reset mid-run oe", int'(sd_oe_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R2 start after reset oe", int'(sd_oe_o), 1);
    check("R2 start after reset msb", int'(sd_o), 0);
    @(negedge clk);
    check("R4 second bit", int'(sd_o), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule